// File: doc/BRIEF.md
# System Manager Power-Control Sequencer

This block takes one-byte commands from a host and turns each into a short, timed sequence on the system control lines. These lines are the reset and NMI of the master CPU, the resets of the slave and sound CPUs, a system-wide reset, a system halt and the dot-clock select. When a command finishes, the block clears a busy flag. Most commands also leave their own opcode in a result register, so the host can confirm which command completed.

Commands enter through a valid/ready port. `cmd_ready_o` is high exactly when the block is not busy. A byte offered while ready is low is not taken and has no effect: the host must offer it again once ready returns. Only one command runs at a time.

The clock-change command is the only one that waits on an external event. It halts the system as soon as it is taken. It holds the halt until the next vertical-blank-start strobe, then switches the dot clock, releases the halt and runs a fixed release sequence. The interrupt-back command gives a single-cycle request pulse toward an interrupt controller, which acts only on the high level.

Top module: `sysmgr_seq`

## Requirements
- R1: After reset, every control output is low except slave reset and sound reset, which are high. The busy flag is low, the result register is 0x00 and the NMI-disable flag is clear.
- R2: `cmd_ready_o` equals the inverse of `busy_o`. A byte offered while ready is high is taken at that clock edge, and busy is high in the next cycle. A byte offered while busy is dropped and changes no output.
- R3: Slave on/off (0x02 = release, 0x03 = hold in reset; bit 0 is the parameter) sets `slv_rst_o` to bit 0 one cycle after it is taken. At the same edge the result register loads the opcode and busy clears.
- R4: Sound on/off (0x06 / 0x07) behaves like R3, but on `snd_rst_o`.
- R5: CD on/off (0x08 / 0x09) changes no control line. One cycle after it is taken, the result register loads the opcode and busy clears.
- R6: Clock change (0x0E / 0x0F) raises `sys_halt_o` in the cycle after it is taken. Halt stays high until a `vblank_start_i` sampled high while waiting. A vblank strobe at any other time has no effect.
- R7: At that vblank edge, `dot_sel_o` takes bit 0 (1 = 320-dot clock, 0 = 352-dot clock) and halt drops. At the next edge, `slv_rst_o` goes high, the result loads the opcode, and `mst_nmi_o` pulses for one cycle unless the NMI-disable flag is set. Busy clears one edge later. `dot_sel_o` changes at no other time.
- R8: System reset (0x0D) drives `sys_rst_o` high for one cycle and then `mst_rst_o` high for one cycle. Busy clears as master reset falls. The result register is unchanged.
- R9: NMI request (0x18) pulses `mst_nmi_o` for one cycle whatever the disable flag holds. Busy clears as the pulse ends.
- R10: NMI disable (0x1A clears, 0x1B sets; bit 0 is the value) writes the NMI-disable flag. No line changes and the result register is unchanged.
- R11: Interrupt-back (0x10) drives `irq_o` high for exactly one cycle and loads 0x10 into the result register, with busy clearing at the same edge.
- R12: Any other byte is taken, changes no output and clears busy one cycle later.
- R13: The result register changes only at the completion edge of a reporting command (R3, R4, R5, R7, R11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command byte offered |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_code_i | input | 8 | Command opcode |
| vblank_start_i | input | 1 | Vertical-blank-start strobe |
| busy_o | output | 1 | Handshake flag, high while a command runs |
| result_o | output | 8 | Opcode of the last reporting command completed |
| mst_rst_o | output | 1 | Master CPU reset |
| mst_nmi_o | output | 1 | Master CPU NMI |
| slv_rst_o | output | 1 | Slave CPU reset |
| snd_rst_o | output | 1 | Sound CPU reset |
| sys_rst_o | output | 1 | System reset |
| sys_halt_o | output | 1 | System halt |
| dot_sel_o | output | 1 | Dot-clock select (1 = 320, 0 = 352) |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The hardest situation to reach from the ports is a clock change that has been waiting an arbitrary time for vertical blank. During that wait a second command is offered and a stray strobe has already arrived while idle, and the NMI-disable flag may have been set by an earlier command. The stimulus draws random wait lengths and random command orders, so disable-flag writes come before some clock changes and not others. In the middle of each wait it offers a command that must be dropped, and it pulses vblank while idle to show that the strobe only counts during the wait.

// File: rtl/sysmgr_pkg.sv
package sysmgr_pkg;

  typedef enum logic [3:0] {
    K_SLAVE, K_SOUND, K_CD, K_CLOCK, K_SYSRST,
    K_NMI, K_NMIDIS, K_INTBACK, K_NOP
  } cmd_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_CLK_WAIT, S_CLK_FIN,
    S_CLK_END, S_SR_SYS, S_SR_MST, S_NMI_END
  } seq_state_t;

endpackage

// File: rtl/sysmgr_decode.sv
module sysmgr_decode
  import sysmgr_pkg::*;
#(
  parameter int          CODE_W     = 8,
  parameter logic [7:0]  OP_SLAVE   = 8'h02,
  parameter logic [7:0]  OP_SOUND   = 8'h06,
  parameter logic [7:0]  OP_CD      = 8'h08,
  parameter logic [7:0]  OP_CLOCK   = 8'h0E,
  parameter logic [7:0]  OP_NMIDIS  = 8'h1A,
  parameter logic [7:0]  OP_SYSRST  = 8'h0D,
  parameter logic [7:0]  OP_NMI     = 8'h18,
  parameter logic [7:0]  OP_INTBACK = 8'h10
) (
  input  logic [CODE_W-1:0] code_i,
  output cmd_kind_t         kind_o,
  output logic              param_o,
  output logic              reports_o
);
  localparam int NPAIR = 5;
  localparam logic [NPAIR*8-1:0] PAIR_BASE =
    {OP_NMIDIS, OP_CLOCK, OP_CD, OP_SOUND, OP_SLAVE};
  localparam logic [NPAIR*4-1:0] PAIR_KIND =
    {4'(K_NMIDIS), 4'(K_CLOCK), 4'(K_CD), 4'(K_SOUND), 4'(K_SLAVE)};
  localparam logic [NPAIR-1:0] PAIR_REPORTS = 5'b01111;

  logic [CODE_W-1:0] even_code;
  assign even_code = {code_i[CODE_W-1:1], 1'b0};
  assign param_o   = code_i[0];

  always_comb begin
    kind_o    = K_NOP;
    reports_o = 1'b0;
    for (int i = 0; i < NPAIR; i++) begin
      if (even_code == CODE_W'(PAIR_BASE[i*8 +: 8])) begin
        kind_o    = cmd_kind_t'(PAIR_KIND[i*4 +: 4]);
        reports_o = PAIR_REPORTS[i];
      end
    end
    if (code_i == CODE_W'(OP_SYSRST)) begin
      kind_o    = K_SYSRST;
      reports_o = 1'b0;
    end
    if (code_i == CODE_W'(OP_NMI)) begin
      kind_o    = K_NMI;
      reports_o = 1'b0;
    end
    if (code_i == CODE_W'(OP_INTBACK)) begin
      kind_o    = K_INTBACK;
      reports_o = 1'b1;
    end
  end
endmodule

// File: rtl/sysmgr_fsm.sv
module sysmgr_fsm
  import sysmgr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  cmd_kind_t kind_i,
  input  logic      param_i,
  input  logic      reports_i,
  input  logic      vblank_i,
  output logic      load_o,
  output logic      done_o,
  output logic      mst_rst_o,
  output logic      mst_nmi_o,
  output logic      slv_rst_o,
  output logic      snd_rst_o,
  output logic      sys_rst_o,
  output logic      sys_halt_o,
  output logic      dot_sel_o,
  output logic      irq_o
);
  seq_state_t state;
  cmd_kind_t  kind_q;
  logic       par_q;
  logic       rep_q;
  logic       nmi_dis;
  logic       multi_step;

  assign multi_step = (kind_q == K_SYSRST) || (kind_q == K_NMI);

  always_comb begin
    load_o = ((state == S_EXEC) && rep_q) || (state == S_CLK_FIN);
    done_o = ((state == S_EXEC) && !multi_step) || (state == S_CLK_END) ||
             (state == S_SR_MST) || (state == S_NMI_END);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      kind_q     <= K_NOP;
      par_q      <= 1'b0;
      rep_q      <= 1'b0;
      nmi_dis    <= 1'b0;
      mst_rst_o  <= 1'b0;
      mst_nmi_o  <= 1'b0;
      slv_rst_o  <= 1'b1;
      snd_rst_o  <= 1'b1;
      sys_rst_o  <= 1'b0;
      sys_halt_o <= 1'b0;
      dot_sel_o  <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            kind_q <= kind_i;
            par_q  <= param_i;
            rep_q  <= reports_i;
            if (kind_i == K_CLOCK) begin
              sys_halt_o <= 1'b1;
              state      <= S_CLK_WAIT;
            end else begin
              state <= S_EXEC;
            end
          end
        end
        S_EXEC: begin
          state <= S_IDLE;
          case (kind_q)
            K_SLAVE:   slv_rst_o <= par_q;
            K_SOUND:   snd_rst_o <= par_q;
            K_INTBACK: irq_o     <= 1'b1;
            K_NMIDIS:  nmi_dis   <= par_q;
            K_SYSRST: begin
              sys_rst_o <= 1'b1;
              state     <= S_SR_SYS;
            end
            K_NMI: begin
              mst_nmi_o <= 1'b1;
              state     <= S_NMI_END;
            end
            default: ;
          endcase
        end
        S_SR_SYS: begin
          sys_rst_o <= 1'b0;
          mst_rst_o <= 1'b1;
          state     <= S_SR_MST;
        end
        S_SR_MST: begin
          mst_rst_o <= 1'b0;
          state     <= S_IDLE;
        end
        S_NMI_END: begin
          mst_nmi_o <= 1'b0;
          state     <= S_IDLE;
        end
        S_CLK_WAIT: begin
          if (vblank_i) begin
            dot_sel_o  <= par_q;
            sys_halt_o <= 1'b0;
            state      <= S_CLK_FIN;
          end
        end
        S_CLK_FIN: begin
          mst_nmi_o <= !nmi_dis;
          slv_rst_o <= 1'b1;
          state     <= S_CLK_END;
        end
        S_CLK_END: begin
          mst_nmi_o <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sysmgr_hshake.sv
module sysmgr_hshake #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] result_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o   <= 1'b0;
      code_q   <= '0;
      result_o <= '0;
    end else begin
      if (accept_i) begin
        busy_o <= 1'b1;
        code_q <= code_i;
      end else if (done_i) begin
        busy_o <= 1'b0;
      end
      if (load_i) result_o <= code_q;
    end
  end
endmodule

// File: rtl/sysmgr_seq.sv
module sysmgr_seq
  import sysmgr_pkg::*;
#(
  parameter int          CODE_W     = 8,
  parameter logic [7:0]  OP_SLAVE   = 8'h02,
  parameter logic [7:0]  OP_SOUND   = 8'h06,
  parameter logic [7:0]  OP_CD      = 8'h08,
  parameter logic [7:0]  OP_CLOCK   = 8'h0E,
  parameter logic [7:0]  OP_NMIDIS  = 8'h1A,
  parameter logic [7:0]  OP_SYSRST  = 8'h0D,
  parameter logic [7:0]  OP_NMI     = 8'h18,
  parameter logic [7:0]  OP_INTBACK = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [CODE_W-1:0] cmd_code_i,
  input  logic              vblank_start_i,
  output logic              busy_o,
  output logic [CODE_W-1:0] result_o,
  output logic              mst_rst_o,
  output logic              mst_nmi_o,
  output logic              slv_rst_o,
  output logic              snd_rst_o,
  output logic              sys_rst_o,
  output logic              sys_halt_o,
  output logic              dot_sel_o,
  output logic              irq_o
);
  cmd_kind_t kind;
  logic      param, reports, accept, load, done;

  assign cmd_ready_o = !busy_o;
  assign accept      = cmd_valid_i && cmd_ready_o;

  sysmgr_decode #(
    .CODE_W(CODE_W), .OP_SLAVE(OP_SLAVE), .OP_SOUND(OP_SOUND), .OP_CD(OP_CD),
    .OP_CLOCK(OP_CLOCK), .OP_NMIDIS(OP_NMIDIS), .OP_SYSRST(OP_SYSRST),
    .OP_NMI(OP_NMI), .OP_INTBACK(OP_INTBACK)
  ) u_dec (
    .code_i(cmd_code_i), .kind_o(kind), .param_o(param), .reports_o(reports)
  );

  sysmgr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .kind_i(kind),
    .param_i(param), .reports_i(reports), .vblank_i(vblank_start_i),
    .load_o(load), .done_o(done),
    .mst_rst_o(mst_rst_o), .mst_nmi_o(mst_nmi_o), .slv_rst_o(slv_rst_o),
    .snd_rst_o(snd_rst_o), .sys_rst_o(sys_rst_o), .sys_halt_o(sys_halt_o),
    .dot_sel_o(dot_sel_o), .irq_o(irq_o)
  );

  sysmgr_hshake #(.CODE_W(CODE_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .code_i(cmd_code_i),
    .load_i(load), .done_i(done), .busy_o(busy_o), .result_o(result_o)
  );
endmodule

// File: rtl/sysmgr_seq_chk.sv
module sysmgr_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic              vblank_start_i,
  input logic              busy_o,
  input logic [CODE_W-1:0] result_o,
  input logic              mst_rst_o,
  input logic              mst_nmi_o,
  input logic              sys_rst_o,
  input logic              sys_halt_o,
  input logic              dot_sel_o,
  input logic              irq_o
);
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cmd_ready_o |=> busy_o); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_halt_o && !vblank_start_i |=> sys_halt_o); // R6
  AST_DOT_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_halt_o |=> $stable(dot_sel_o)); // R7
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mst_nmi_o |=> !mst_nmi_o); // R9
  AST_SYSRST_THEN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> mst_rst_o && !sys_rst_o); // R8
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R11
  AST_RESULT_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(result_o)); // R13
endmodule

bind sysmgr_seq sysmgr_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .vblank_start_i(vblank_start_i), .busy_o(busy_o), .result_o(result_o),
  .mst_rst_o(mst_rst_o), .mst_nmi_o(mst_nmi_o), .sys_rst_o(sys_rst_o),
  .sys_halt_o(sys_halt_o), .dot_sel_o(dot_sel_o), .irq_o(irq_o)
);

// File: tb/sysmgr_seq_tb.sv
module sysmgr_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [7:0] cmd_code_i = 8'h00;
  logic       vblank_start_i = 1'b0;
  logic       cmd_ready_o, busy_o;
  logic [7:0] result_o;
  logic       mst_rst_o, mst_nmi_o, slv_rst_o, snd_rst_o;
  logic       sys_rst_o, sys_halt_o, dot_sel_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic       e_slv, e_snd, e_dot, e_dis;
  logic [7:0] e_res;

  always #4 clk = ~clk;

  sysmgr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_code_i(cmd_code_i), .vblank_start_i(vblank_start_i), .busy_o(busy_o),
    .result_o(result_o), .mst_rst_o(mst_rst_o), .mst_nmi_o(mst_nmi_o),
    .slv_rst_o(slv_rst_o), .snd_rst_o(snd_rst_o), .sys_rst_o(sys_rst_o),
    .sys_halt_o(sys_halt_o), .dot_sel_o(dot_sel_o), .irq_o(irq_o)
  );

  // Command classes taken from the requirement text.
  function automatic int kind_of(logic [7:0] op);
    logic [7:0] ev = {op[7:1], 1'b0};
    if (op == 8'h0D) return 4;
    if (op == 8'h18) return 5;
    if (op == 8'h10) return 7;
    if (ev == 8'h02) return 0;
    if (ev == 8'h06) return 1;
    if (ev == 8'h08) return 2;
    if (ev == 8'h0E) return 3;
    if (ev == 8'h1A) return 6;
    return 8;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_lines(string req, logic nmi, logic mst, logic sys, logic halt, logic irq);
    chk(req, {mst_nmi_o, mst_rst_o, sys_rst_o, sys_halt_o, irq_o},
             {nmi, mst, sys, halt, irq});
    chk(req, {slv_rst_o, snd_rst_o, dot_sel_o, result_o[0]},
             {e_slv, e_snd, e_dot, e_res[0]});
    chk(req, result_o, e_res);
  endtask

  task automatic offer(logic [7:0] op);
    while (!cmd_ready_o) @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_code_i  = op;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk("R2 busy after accept", {busy_o, cmd_ready_o}, 8'h2);
  endtask

  task automatic run_cmd(logic [7:0] op);
    int k = kind_of(op);
    offer(op);
    case (k)
      0, 1, 2, 6, 8: begin
        @(negedge clk);
        if (k == 0) e_slv = op[0];
        if (k == 1) e_snd = op[0];
        if (k == 6) e_dis = op[0];
        if (k <= 2) e_res = op;
        chk_lines(k == 0 ? "R3 slave" : k == 1 ? "R4 sound" : k == 2 ? "R5 cd" :
                  k == 6 ? "R10 nmi disable" : "R12 unknown", 0, 0, 0, 0, 0);
        chk("R12 busy clears", busy_o, 0);
      end
      7: begin
        @(negedge clk);
        e_res = 8'h10;
        chk_lines("R11 irq high", 0, 0, 0, 0, 1);
        chk("R11 busy clears", busy_o, 0);
        @(negedge clk);
        chk_lines("R11 irq low", 0, 0, 0, 0, 0);
      end
      5: begin
        @(negedge clk);
        chk_lines("R9 nmi high", 1, 0, 0, 0, 0);
        chk("R9 busy held", busy_o, 1);
        @(negedge clk);
        chk_lines("R9 nmi low", 0, 0, 0, 0, 0);
        chk("R9 busy clears", busy_o, 0);
      end
      4: begin
        @(negedge clk);
        chk_lines("R8 sys reset", 0, 0, 1, 0, 0);
        @(negedge clk);
        chk_lines("R8 master reset", 0, 1, 0, 0, 0);
        chk("R8 busy held", busy_o, 1);
        @(negedge clk);
        chk_lines("R8 end", 0, 0, 0, 0, 0);
        chk("R8 busy clears", busy_o, 0);
      end
      3: begin
        int w = $urandom_range(0, 4);
        chk_lines("R6 halt on accept", 0, 0, 0, 1, 0);
        for (int i = 0; i < w; i++) begin
          if (i == 0) begin
            cmd_valid_i = 1'b1;
            cmd_code_i  = 8'h0D;
          end
          @(negedge clk);
          cmd_valid_i = 1'b0;
          chk_lines("R6 halt held / R2 drop", 0, 0, 0, 1, 0);
          chk("R2 busy in wait", busy_o, 1);
        end
        vblank_start_i = 1'b1;
        @(negedge clk);
        vblank_start_i = 1'b0;
        e_dot = op[0];
        chk_lines("R7 release", 0, 0, 0, 0, 0);
        @(negedge clk);
        e_slv = 1'b1;
        e_res = op;
        chk_lines("R7 nmi step", !e_dis, 0, 0, 0, 0);
        chk("R7 busy held", busy_o, 1);
        @(negedge clk);
        chk_lines("R7 end", 0, 0, 0, 0, 0);
        chk("R7 busy clears", busy_o, 0);
      end
      default: ;
    endcase
  endtask

  initial begin
    logic [7:0] pool [14] = '{8'h02, 8'h03, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0E,
                              8'h0F, 8'h0D, 8'h18, 8'h1A, 8'h1B, 8'h10, 8'h55};
    void'($urandom(32'd1234));
    e_slv = 1; e_snd = 1; e_dot = 0; e_dis = 0; e_res = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_lines("R1 reset state", 0, 0, 0, 0, 0);
    chk("R1 busy/ready", {busy_o, cmd_ready_o}, 8'h1);

    vblank_start_i = 1'b1;
    @(negedge clk);
    vblank_start_i = 1'b0;
    chk_lines("R6 vblank idle ignored", 0, 0, 0, 0, 0);

    run_cmd(8'h03); run_cmd(8'h02); run_cmd(8'h07); run_cmd(8'h09);
    run_cmd(8'h0F);
    run_cmd(8'h1B); run_cmd(8'h0E);
    run_cmd(8'h18);
    run_cmd(8'h1A); run_cmd(8'h0F);
    run_cmd(8'h0D); run_cmd(8'h10); run_cmd(8'hFF);

    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 5) == 0) run_cmd(8'($urandom));
      else run_cmd(pool[$urandom_range(0, 13)]);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule